// File: doc/BRIEF.md
# Leading-One Position Encoder

This block is a purely combinational encoder. It looks at a parameterizable input vector, 16 bits wide by default, and reports where the most significant set bit sits. The output is one-based: a set bit at index `i` gives the code `i+1`. The code zero is kept for an input with no bit set, so a consumer can test for "nothing set" and read the position from the same bus.

A build-time parameter picks one of four implementation styles. The first is a one-hot-assuming encoder, which merges the codes of every set bit. The second is a balanced priority tree. The third is a loop that scans from the top bit down and stops at the first hit. The fourth is a loop that scans from the bottom bit up and overwrites its result at every set bit. The three priority styles agree on any input. The one-hot style agrees with them only when at most one bit is set, and it costs the least logic. Clocking and registering are left to the surrounding design.

Top module: `lop_enc`

## Requirements
- R1: For an input with exactly one bit set, at index i, every style outputs i+1. Bit 0 gives 1, and the top bit gives WIDTH.
- R2: When the input is all zero, every style outputs 0.
- R3: When several bits are set, the priority styles (STYLE 1 tree, 2 downward scan, 3 upward scan) output the index of the highest set bit plus one. Lower set bits have no effect.
- R4: The output is ceil(log2(WIDTH+1)) bits wide: 5 bits for WIDTH 16 and 3 bits for WIDTH 7.
- R5: The one-hot style (STYLE 0) outputs the bitwise OR of (i+1) over all set bits i. For example, bits 15 and 0 set at WIDTH 16 give 17.
- R6: For any input, the three priority styles give the same output.
- R7: In every style, the output is nonzero exactly when at least one input bit is set.
- R8: In the priority styles, the output never exceeds WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_i | input | WIDTH | Vector to be searched |
| pos_o | output | CODE_W = ceil(log2(WIDTH+1)) | One-based position of the highest set bit; 0 when no bit is set |

## Verification
The bench builds the block at WIDTH 16 in all four styles, side by side, and drives the same vector into each copy. This lets it compare the styles against one another as well as against its own reference. It also builds WIDTH 7 copies in the one-hot, tree and downward-scan styles. At that width the tree has to pad up to eight leaves, and the 3-bit output is at its limit, so the odd-width edge cases come within reach. The patterns driven are the all-zero vector, every one-hot position, the all-ones vector, chosen pairs of bits, and random vectors.

// File: rtl/lop_pkg.sv
package lop_pkg;

  // Implementation style selectors
  localparam int LOP_ONEHOT    = 0;
  localparam int LOP_TREE      = 1;
  localparam int LOP_SCAN_DOWN = 2;
  localparam int LOP_SCAN_UP   = 3;

  // Bits needed to hold the codes 0..width
  function automatic int code_width(input int width);
    return (width < 1) ? 1 : $clog2(width + 1);
  endfunction

  // One-based code of a bit index
  function automatic int slot_code(input int idx);
    return idx + 1;
  endfunction

  // Leaves of the priority tree, padded up to a power of two
  function automatic int tree_leaves(input int width);
    return 1 << $clog2((width < 1) ? 1 : width);
  endfunction

endpackage

// File: rtl/lop_onehot.sv
module lop_onehot #(
  parameter int WIDTH  = 16,
  parameter int CODE_W = lop_pkg::code_width(WIDTH)
) (
  input  logic [WIDTH-1:0]  vec_i,
  output logic [CODE_W-1:0] code_o
);
  // Assumes at most one bit is set: codes of all set bits are merged by OR
  always_comb begin
    code_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vec_i[i]) code_o = code_o | CODE_W'(lop_pkg::slot_code(i));
    end
  end
endmodule

// File: rtl/lop_tree.sv
module lop_tree #(
  parameter int WIDTH  = 16,
  parameter int CODE_W = lop_pkg::code_width(WIDTH)
) (
  input  logic [WIDTH-1:0]  vec_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int LEAVES = lop_pkg::tree_leaves(WIDTH);
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap layout: node k has children 2k+1 (lower bits) and 2k+2 (higher bits)
  logic [CODE_W-1:0] node [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < WIDTH) begin : g_real
      assign node[LEAVES-1+i] = vec_i[i] ? CODE_W'(lop_pkg::slot_code(i)) : '0;
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    assign node[k] = (node[2*k+2] != '0) ? node[2*k+2] : node[2*k+1];
  end

  assign code_o = node[0];
endmodule

// File: rtl/lop_scan.sv
module lop_scan #(
  parameter int WIDTH   = 16,
  parameter bit UPWARD  = 1'b0,
  parameter int CODE_W  = lop_pkg::code_width(WIDTH)
) (
  input  logic [WIDTH-1:0]  vec_i,
  output logic [CODE_W-1:0] code_o
);
  if (UPWARD) begin : g_up
    // Last match wins: every set bit overwrites, no early exit
    always_comb begin
      code_o = '0;
      for (int i = 0; i < WIDTH; i++) begin
        if (vec_i[i]) code_o = CODE_W'(lop_pkg::slot_code(i));
      end
    end
  end else begin : g_down
    // First match from the top wins; a flag blocks later hits
    logic hit;
    always_comb begin
      code_o = '0;
      hit    = 1'b0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
        if (!hit && vec_i[i]) begin
          code_o = CODE_W'(lop_pkg::slot_code(i));
          hit    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lop_enc.sv
module lop_enc #(
  parameter int WIDTH  = 16,
  parameter int STYLE  = lop_pkg::LOP_TREE,
  localparam int CODE_W = lop_pkg::code_width(WIDTH)
) (
  input  logic [WIDTH-1:0]  vec_i,
  output logic [CODE_W-1:0] pos_o
);
  // Named internal events for the checker
  logic              none_set;
  logic [CODE_W-1:0] sel_code;

  assign none_set = (vec_i == '0);

  case (STYLE)
    lop_pkg::LOP_ONEHOT: begin : g_onehot
      lop_onehot #(.WIDTH(WIDTH), .CODE_W(CODE_W)) u_var (
        .vec_i(vec_i), .code_o(sel_code));
    end
    lop_pkg::LOP_SCAN_DOWN: begin : g_down
      lop_scan #(.WIDTH(WIDTH), .UPWARD(1'b0), .CODE_W(CODE_W)) u_var (
        .vec_i(vec_i), .code_o(sel_code));
    end
    lop_pkg::LOP_SCAN_UP: begin : g_up
      lop_scan #(.WIDTH(WIDTH), .UPWARD(1'b1), .CODE_W(CODE_W)) u_var (
        .vec_i(vec_i), .code_o(sel_code));
    end
    default: begin : g_tree
      lop_tree #(.WIDTH(WIDTH), .CODE_W(CODE_W)) u_var (
        .vec_i(vec_i), .code_o(sel_code));
    end
  endcase

  assign pos_o = sel_code;
endmodule

// File: rtl/lop_enc_chk.sv
module lop_enc_chk #(
  parameter int WIDTH  = 16,
  parameter int STYLE  = 1,
  parameter int CODE_W = lop_pkg::code_width(WIDTH)
) (
  input logic [WIDTH-1:0]  vec_i,
  input logic [CODE_W-1:0] pos_o,
  input logic              none_set
);
  int p;
  assign p = int'(pos_o);

  always_comb begin
    if (!$isunknown({vec_i, pos_o, none_set})) begin
      // R2
      zero_in_zero_out_chk: assert (!none_set || pos_o == '0)
        else $error("R2: nonzero code for empty input");
      // R7
      nonzero_flag_chk: assert (none_set || pos_o != '0)
        else $error("R7: zero code for nonempty input");
      // R1
      if ($onehot(vec_i)) begin
        onehot_pos_chk: assert (p >= 1 && p <= WIDTH && vec_i[(p >= 1 && p <= WIDTH) ? p-1 : 0])
          else $error("R1: one-hot position wrong");
      end
      if (STYLE != 0) begin
        // R8
        code_range_chk: assert (p <= WIDTH)
          else $error("R8: code above width");
        // R3
        if (p >= 1 && p <= WIDTH) begin
          highest_set_chk: assert (vec_i[p-1] && ((vec_i >> p) == '0))
            else $error("R3: reported bit is not the highest set bit");
        end
      end
    end
  end
endmodule

bind lop_enc lop_enc_chk #(.WIDTH(WIDTH), .STYLE(STYLE), .CODE_W(CODE_W)) u_chk (
  .vec_i(vec_i), .pos_o(pos_o), .none_set(none_set));

// File: tb/lop_enc_tb.sv
module lop_enc_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] vec = '0;
  logic [6:0]  vec7;
  assign vec7 = vec[6:0];

  logic [4:0] o_tree, o_oh, o_dn, o_up;
  logic [2:0] o7_oh, o7_tree, o7_dn;

  lop_enc #(.WIDTH(16), .STYLE(1)) u_dut     (.vec_i(vec),  .pos_o(o_tree));
  lop_enc #(.WIDTH(16), .STYLE(0)) u_dut_oh  (.vec_i(vec),  .pos_o(o_oh));
  lop_enc #(.WIDTH(16), .STYLE(2)) u_dut_dn  (.vec_i(vec),  .pos_o(o_dn));
  lop_enc #(.WIDTH(16), .STYLE(3)) u_dut_up  (.vec_i(vec),  .pos_o(o_up));
  lop_enc #(.WIDTH(7),  .STYLE(0)) u_dut7_oh (.vec_i(vec7), .pos_o(o7_oh));
  lop_enc #(.WIDTH(7),  .STYLE(1)) u_dut7_tr (.vec_i(vec7), .pos_o(o7_tree));
  lop_enc #(.WIDTH(7),  .STYLE(2)) u_dut7_dn (.vec_i(vec7), .pos_o(o7_dn));

  // Reference: count shifts until the value empties
  function automatic int ref_hi(input logic [15:0] v);
    int n = 0;
    logic [15:0] t = v;
    while (t != 0) begin t = t >> 1; n++; end
    return n;
  endfunction

  // Reference for the one-hot style: merge of all one-based codes
  function automatic int ref_or(input logic [15:0] v, input int w);
    int r = 0;
    for (int i = 0; i < w; i++) if (v[i]) r = r | (i + 1);
    return r;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s vec=%h actual=%0d expected=%0d", req, what, vec, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] v);
    @(negedge clk);
    vec = v;
    #1;
  endtask

  // Checks all 16-bit copies against the references
  task automatic check_all16(input string req);
    int hi = ref_hi(vec);
    check(req, "tree",     int'(o_tree), hi);
    check(req, "scan_dn",  int'(o_dn),   hi);
    check(req, "scan_up",  int'(o_up),   hi);
    check(req, "onehot",   int'(o_oh),   ref_or(vec, 16));
  endtask

  task automatic check_all7(input string req);
    int hi = ref_hi({9'b0, vec7});
    check(req, "w7_tree",   int'(o7_tree), hi);
    check(req, "w7_dn",     int'(o7_dn),   hi);
    check(req, "w7_onehot", int'(o7_oh),   ref_or({9'b0, vec7}, 7));
  endtask

  task automatic t_zero;
    apply(16'h0000);
    check("R2", "tree", int'(o_tree), 0);
    check("R2", "onehot", int'(o_oh), 0);
    check("R2", "w7_dn", int'(o7_dn), 0);
    check_all16("R2");
  endtask

  task automatic t_onehot_walk;
    for (int i = 0; i < 16; i++) begin
      apply(16'h1 << i);
      check("R1", "tree", int'(o_tree), i + 1);
      check("R1", "onehot", int'(o_oh), i + 1);
      check("R1", "scan_dn", int'(o_dn), i + 1);
      check("R1", "scan_up", int'(o_up), i + 1);
    end
    apply(16'h8000);
    check("R4", "top bit gives width", int'(o_tree), 16);
  endtask

  task automatic t_all_ones;
    apply(16'hFFFF);
    check("R3", "tree", int'(o_tree), 16);
    check("R3", "scan_up", int'(o_up), 16);
    check("R5", "onehot all ones", int'(o_oh), 31);
    check("R8", "tree bound", int'(o_tree <= 5'd16), 1);
  endtask

  task automatic t_pairs;
    apply(16'h8001);
    check("R3", "bits 15,0 tree", int'(o_tree), 16);
    check("R3", "bits 15,0 scan_dn", int'(o_dn), 16);
    check("R5", "bits 15,0 onehot", int'(o_oh), 17);
    apply(16'h0028);
    check("R3", "bits 5,3 scan_up", int'(o_up), 6);
    check("R5", "bits 5,3 onehot", int'(o_oh), 6 | 4);
    apply(16'h0300);
    check_all16("R3");
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++) begin
      apply(16'($urandom));
      check_all16("R6");
      check("R6", "dn vs up", int'(o_dn), int'(o_up));
      check("R7", "nonzero", int'(o_oh != 0), int'(vec != 0));
      check("R8", "range", int'(o_tree <= 5'd16), 1);
    end
  endtask

  task automatic t_narrow;
    apply(16'h0000);
    check_all7("R2");
    for (int i = 0; i < 7; i++) begin
      apply(16'h1 << i);
      check("R1", "w7_tree", int'(o7_tree), i + 1);
      check("R1", "w7_onehot", int'(o7_oh), i + 1);
    end
    apply(16'hFF80);
    check("R7", "w7 ignores bits above width", int'(o7_tree), 0);
    apply(16'h007F);
    check("R4", "w7 max code", int'(o7_tree), 7);
    check("R5", "w7 onehot all ones", int'(o7_oh), 7);
    for (int n = 0; n < 100; n++) begin
      apply(16'($urandom));
      check_all7("R6");
    end
  endtask

  initial begin
    t_zero();
    t_onehot_walk();
    t_all_ones();
    t_pairs();
    t_random();
    t_narrow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule